// File: doc/BRIEF.md
# Bus Phase Interrupt Status Latch

This block gathers bus-level events for a parallel bus controller that can work either as initiator or as target. Each event is captured into a sticky bit of an 8-bit status register. A single interrupt line goes high whenever a captured bit is also enabled in a per-bit mask.

One bit has two meanings, chosen by the mode input. In initiator mode it records a phase mismatch. The block detects this on the rising edge of REQ, comparing the three phase lines the target drives against the phase the controller expects. In target mode the same bit records that the initiator is holding ATN.

Other bits record:
- completion of an arbitration and selection sequence;
- being selected, if responding to selection is enabled;
- being reselected, if responding to reselection is enabled;
- a gross error reported by a separate detector.

Software reads the register with a one-cycle read strobe. The read returns the current value and clears all bits.

Top module: `bus_evt_status`

## Requirements
- R1: While `rst` is high at a clock edge, `status_q`, the interrupt mask and `irq` are all cleared to zero after that edge.
- R2: In initiator mode (`tgt_mode`=0), a rising edge of `req_in` (high now, low in the previous cycle) while `phase_in` differs from `exp_phase` sets bit 7 after that clock edge. If the phases are equal, bit 7 is not set.
- R3: In initiator mode, the phase comparison happens only on the rising edge of `req_in`. While REQ stays high, changing `phase_in` to a mismatching value does not set bit 7.
- R4: In target mode (`tgt_mode`=1), `atn_in` high at a clock edge sets bit 7. In target mode a REQ edge with a phase mismatch does not set bit 7. In initiator mode `atn_in` does not set bit 7.
- R5: A one-cycle `arbsel_done` pulse sets bit 6 after that edge.
- R6: A `selected_evt` pulse sets bit 5 only when `sel_resp_en` is 1 in the same cycle. Otherwise bit 5 stays 0.
- R7: A `reselected_evt` pulse sets bit 4 only when `resel_resp_en` is 1 in the same cycle. Otherwise bit 4 stays 0.
- R8: A `gross_err` pulse sets bit 3 after that edge.
- R9: Status bits are sticky. They stay set until a cycle with `rd_stb`=1. During that cycle `status_q` shows the value being read, and after that edge every bit is cleared, except bits whose event occurs in the read cycle itself, which stay set.
- R10: Bits 2 to 0 of `status_q` always read as zero.
- R11: A cycle with `mask_wr`=1 loads `mask_din` into the mask. `irq` is the OR of (status AND mask) and changes on the same edge as `status_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_mode | input | 1 | 1 = target mode, 0 = initiator mode |
| phase_in | input | 3 | Sampled bus phase lines {MSG, C/D, I/O} |
| req_in | input | 1 | Sampled REQ line |
| atn_in | input | 1 | Sampled ATN line |
| exp_phase | input | 3 | Expected phase from the output-control latch |
| sel_resp_en | input | 1 | Enable response to selection |
| resel_resp_en | input | 1 | Enable response to reselection |
| arbsel_done | input | 1 | Arbitration and selection complete strobe |
| selected_evt | input | 1 | Selected by an initiator strobe |
| reselected_evt | input | 1 | Reselected by a target strobe |
| gross_err | input | 1 | Gross error strobe from the error detector |
| rd_stb | input | 1 | Status read strobe, clears on read |
| mask_wr | input | 1 | Interrupt mask write strobe |
| mask_din | input | 8 | Interrupt mask write data |
| status_q | output | 8 | Status register value |
| irq | output | 1 | Interrupt request |

## Verification
A stale REQ history register would show one cycle after a REQ edge as a missing or duplicated bit 7, or as bit 7 set while REQ is held high. A wrong mode select would show as ATN or a mismatch landing in bit 7 in the wrong mode. A clear path that loses same-cycle events would show as a zero on `status_q` in the cycle after a read. A mask or interrupt register out of step would show as `irq` disagreeing with `status_q` on the same edge.

// File: rtl/bus_evt_pkg.sv
package bus_evt_pkg;
  localparam int STAT_W  = 8;
  localparam int PHASE_W = 3;
  localparam int B_PHASE = 7;
  localparam int B_CMP   = 6;
  localparam int B_SEL   = 5;
  localparam int B_RSL   = 4;
  localparam int B_GERR  = 3;
  localparam logic [STAT_W-1:0] LIVE_BITS = 8'hF8;
  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/bus_evt_phase_watch.sv
module bus_evt_phase_watch #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tgt_mode,
  input  logic [PW-1:0] phase_in,
  input  logic [PW-1:0] exp_phase,
  input  logic          req_in,
  input  logic          atn_in,
  output logic          bit7_set
);
  logic req_d;
  logic req_rise;
  logic mism;

  always_ff @(posedge clk) begin
    if (rst) req_d <= 1'b0;
    else     req_d <= req_in;
  end

  always_comb begin
    req_rise = req_in & ~req_d;
    mism     = (phase_in != exp_phase);
    if (tgt_mode) bit7_set = atn_in;
    else          bit7_set = req_rise & mism;
  end
endmodule

// File: rtl/bus_evt_status_reg.sv
module bus_evt_status_reg
  import bus_evt_pkg::*;
#(
  parameter int SW = STAT_W,
  parameter logic [SW-1:0] KEEP = LIVE_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_stb,
  input  logic [SW-1:0] set_vec,
  output logic [SW-1:0] stat_nxt,
  output logic [SW-1:0] stat_q
);
  logic [SW-1:0] held;

  always_comb begin
    held     = rd_stb ? '0 : stat_q;
    stat_nxt = (held | set_vec) & KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_nxt;
  end
endmodule

// File: rtl/bus_evt_irq_gen.sv
module bus_evt_irq_gen #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mask_wr,
  input  logic [SW-1:0] mask_din,
  input  logic [SW-1:0] stat_nxt,
  output logic [SW-1:0] mask_q,
  output logic          irq_q
);
  logic [SW-1:0] mask_nxt;

  always_comb mask_nxt = mask_wr ? mask_din : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_nxt;
      irq_q  <= |(stat_nxt & mask_nxt);
    end
  end
endmodule

// File: rtl/bus_evt_status.sv
module bus_evt_status
  import bus_evt_pkg::*;
#(
  parameter int PW = PHASE_W,
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tgt_mode,
  input  logic [PW-1:0] phase_in,
  input  logic          req_in,
  input  logic          atn_in,
  input  logic [PW-1:0] exp_phase,
  input  logic          sel_resp_en,
  input  logic          resel_resp_en,
  input  logic          arbsel_done,
  input  logic          selected_evt,
  input  logic          reselected_evt,
  input  logic          gross_err,
  input  logic          rd_stb,
  input  logic          mask_wr,
  input  logic [SW-1:0] mask_din,
  output logic [SW-1:0] status_q,
  output logic          irq
);
  logic          bit7_set;
  logic [SW-1:0] set_vec;
  logic [SW-1:0] stat_nxt;
  logic [SW-1:0] mask_q;

  bus_evt_phase_watch #(.PW(PW)) u_phase (
    .clk(clk), .rst(rst), .tgt_mode(tgt_mode),
    .phase_in(phase_in), .exp_phase(exp_phase),
    .req_in(req_in), .atn_in(atn_in), .bit7_set(bit7_set)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_PHASE] = bit7_set;
    set_vec[B_CMP]   = arbsel_done;
    set_vec[B_SEL]   = selected_evt & sel_resp_en;
    set_vec[B_RSL]   = reselected_evt & resel_resp_en;
    set_vec[B_GERR]  = gross_err;
  end

  bus_evt_status_reg #(.SW(SW), .KEEP(LIVE_BITS)) u_stat (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .set_vec(set_vec),
    .stat_nxt(stat_nxt), .stat_q(status_q)
  );

  bus_evt_irq_gen #(.SW(SW)) u_irq (
    .clk(clk), .rst(rst), .mask_wr(mask_wr), .mask_din(mask_din),
    .stat_nxt(stat_nxt), .mask_q(mask_q), .irq_q(irq)
  );
endmodule

// File: rtl/bus_evt_status_chk.sv
module bus_evt_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       sel_resp_en,
  input logic       resel_resp_en,
  input logic       arbsel_done,
  input logic       selected_evt,
  input logic       reselected_evt,
  input logic       gross_err,
  input logic       rd_stb,
  input logic [7:0] status_q,
  input logic [7:0] mask_q,
  input logic       irq
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (status_q == 8'h00 && !irq));

  assert_cmp_sets_R5: assert property (@(posedge clk) disable iff (rst)
    arbsel_done |=> status_q[6]);

  assert_sel_gated_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[5]) |-> $past(selected_evt && sel_resp_en));

  assert_resel_gated_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[4]) |-> $past(reselected_evt && resel_resp_en));

  assert_gerr_sets_R8: assert property (@(posedge clk) disable iff (rst)
    gross_err |=> status_q[3]);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (rst)
    status_q[2:0] == 3'b000);

  assert_irq_match_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == |(status_q & mask_q)));
endmodule

bind bus_evt_status bus_evt_status_chk u_chk (
  .clk(clk), .rst(rst), .sel_resp_en(sel_resp_en),
  .resel_resp_en(resel_resp_en), .arbsel_done(arbsel_done),
  .selected_evt(selected_evt), .reselected_evt(reselected_evt),
  .gross_err(gross_err), .rd_stb(rd_stb), .status_q(status_q),
  .mask_q(mask_q), .irq(irq)
);

// File: tb/bus_evt_status_tb_top.sv
`timescale 1ns/1ps
module bus_evt_status_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       tgt_mode;
  logic [2:0] phase_in;
  logic       req_in;
  logic       atn_in;
  logic [2:0] exp_phase;
  logic       sel_resp_en;
  logic       resel_resp_en;
  logic       arbsel_done;
  logic       selected_evt;
  logic       reselected_evt;
  logic       gross_err;
  logic       rd_stb;
  logic       mask_wr;
  logic [7:0] mask_din;
  logic [7:0] status_q;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bus_evt_status dut_i (
    .clk(clk), .rst(rst), .tgt_mode(tgt_mode), .phase_in(phase_in),
    .req_in(req_in), .atn_in(atn_in), .exp_phase(exp_phase),
    .sel_resp_en(sel_resp_en), .resel_resp_en(resel_resp_en),
    .arbsel_done(arbsel_done), .selected_evt(selected_evt),
    .reselected_evt(reselected_evt), .gross_err(gross_err),
    .rd_stb(rd_stb), .mask_wr(mask_wr), .mask_din(mask_din),
    .status_q(status_q), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // read-and-clear: status_q seen during the read cycle is returned
  task automatic do_read(output logic [7:0] v);
    rd_stb = 1'b1;
    #1 v = status_q;
    tick();
    rd_stb = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick();
    check("R1 status after reset", status_q, 8'h00);
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
    rst = 1'b0; tick();
    check("R1 status idle", status_q, 8'h00);
  endtask

  task automatic t_init_mismatch();
    logic [7:0] v;
    tgt_mode = 1'b0; exp_phase = 3'b010; phase_in = 3'b010;
    req_in = 1'b1; tick();
    check("R2 match no set", status_q, 8'h00);
    req_in = 1'b0; tick();
    phase_in = 3'b011; req_in = 1'b1; tick();
    check("R2 mismatch sets bit7", status_q, 8'h80);
    req_in = 1'b0; do_read(v);
    check("R2 read value", v, 8'h80);
  endtask

  task automatic t_req_edge();
    tgt_mode = 1'b0; exp_phase = 3'b000; phase_in = 3'b000;
    req_in = 1'b1; tick();
    phase_in = 3'b111; tick(); tick();
    check("R3 held REQ no set", status_q, 8'h00);
    req_in = 1'b0; phase_in = 3'b000; tick();
  endtask

  task automatic t_target_atn();
    logic [7:0] v;
    tgt_mode = 1'b0; atn_in = 1'b1; tick();
    check("R4 ATN ignored initiator", status_q, 8'h00);
    atn_in = 1'b0;
    tgt_mode = 1'b1; exp_phase = 3'b001; phase_in = 3'b110;
    req_in = 1'b1; tick();
    check("R4 mismatch ignored target", status_q, 8'h00);
    req_in = 1'b0; atn_in = 1'b1; tick();
    check("R4 ATN sets bit7", status_q, 8'h80);
    atn_in = 1'b0; do_read(v);
    tgt_mode = 1'b0; phase_in = 3'b000; exp_phase = 3'b000;
    check("R4 cleared", status_q, 8'h00);
  endtask

  task automatic t_arbsel();
    logic [7:0] v;
    arbsel_done = 1'b1; tick(); arbsel_done = 1'b0;
    check("R5 cmp bit6", status_q, 8'h40);
    do_read(v);
  endtask

  task automatic t_select();
    logic [7:0] v;
    sel_resp_en = 1'b0; selected_evt = 1'b1; tick(); selected_evt = 1'b0;
    check("R6 sel disabled", status_q, 8'h00);
    sel_resp_en = 1'b1; selected_evt = 1'b1; tick(); selected_evt = 1'b0;
    check("R6 sel bit5", status_q, 8'h20);
    do_read(v);
  endtask

  task automatic t_reselect();
    logic [7:0] v;
    resel_resp_en = 1'b0; reselected_evt = 1'b1; tick(); reselected_evt = 1'b0;
    check("R7 resel disabled", status_q, 8'h00);
    resel_resp_en = 1'b1; reselected_evt = 1'b1; tick(); reselected_evt = 1'b0;
    check("R7 resel bit4", status_q, 8'h10);
    do_read(v);
  endtask

  task automatic t_gross();
    logic [7:0] v;
    gross_err = 1'b1; tick(); gross_err = 1'b0;
    check("R8 gerr bit3", status_q, 8'h08);
    do_read(v);
  endtask

  task automatic t_read_clear();
    logic [7:0] v;
    arbsel_done = 1'b1; tick(); arbsel_done = 1'b0;
    gross_err = 1'b1; tick(); gross_err = 1'b0;
    tick(); tick();
    check("R9 sticky", status_q, 8'h48);
    check("R10 reserved zero", {5'd0, status_q[2:0]}, 8'h00);
    rd_stb = 1'b1; gross_err = 1'b1;
    #1 v = status_q;
    tick();
    rd_stb = 1'b0; gross_err = 1'b0;
    check("R9 read value", v, 8'h48);
    check("R9 same-cycle event kept", status_q, 8'h08);
    do_read(v);
    check("R9 cleared", status_q, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    mask_din = 8'h40; mask_wr = 1'b1; tick(); mask_wr = 1'b0;
    gross_err = 1'b1; tick(); gross_err = 1'b0;
    check("R11 masked bit no irq", {7'd0, irq}, 8'h00);
    arbsel_done = 1'b1; tick(); arbsel_done = 1'b0;
    check("R11 enabled bit irq", {7'd0, irq}, 8'h01);
    do_read(v);
    check("R11 irq drops with clear", {7'd0, irq}, 8'h00);
    gross_err = 1'b1; tick(); gross_err = 1'b0;
    mask_din = 8'h08; mask_wr = 1'b1; tick(); mask_wr = 1'b0;
    check("R11 mask write raises irq", {7'd0, irq}, 8'h01);
    do_read(v);
  endtask

  initial begin
    rst = 1'b1; tgt_mode = 1'b0; phase_in = 3'b000; req_in = 1'b0;
    atn_in = 1'b0; exp_phase = 3'b000; sel_resp_en = 1'b0;
    resel_resp_en = 1'b0; arbsel_done = 1'b0; selected_evt = 1'b0;
    reselected_evt = 1'b0; gross_err = 1'b0; rd_stb = 1'b0;
    mask_wr = 1'b0; mask_din = 8'h00;
    tick();
    t_reset();
    t_init_mismatch();
    t_req_edge();
    t_target_atn();
    t_arbsel();
    t_select();
    t_reselect();
    t_gross();
    t_read_clear();
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule